// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block supplies the address for every beat of a four-beat burst into a synchronous memory. A burst begins when one of two active-low start strobes is accepted. One strobe comes from the processor side and the other from the controller side. On that clock edge the block registers the whole input address. After that, each clock edge with the active-low advance input asserted moves to the next beat. Only the two low address bits change. The upper bits keep the value captured at the start.

A static order-select input chooses between two beat orders. Linear order adds the beat number to the starting low bits, modulo four. Interleaved order combines them with XOR. The memory array, the write path and the output drivers belong to the surrounding design. This block owns only the burst address.

Top module: `burst_addr_gen`

## Requirements
- R1: While the active-low reset is asserted, `addrOut` is zero.
- R2: A clock edge with `procStrobeN` low and `chipEnN` low starts a burst. From the next cycle, `addrOut` equals the `addrIn` value sampled on that edge.
- R3: A clock edge with `ctrlStrobeN` low and `chipEnN` low starts a burst in the same way. This also applies when both strobes are low together.
- R4: When `chipEnN` is high, a low `procStrobeN` is ignored. The cycle behaves as if the strobe were high, so `advN` alone decides between holding and stepping.
- R5: A clock edge with `ctrlStrobeN` low and `chipEnN` high is a deselect. `addrOut` holds its value even if `advN` is low.
- R6: With no burst start and no deselect, a low `advN` moves to the next beat, and a high `advN` holds `addrOut` unchanged.
- R7: With `modeSel` = 0 (linear), the low two bits after n steps equal (start + n) mod 4. A start at 1 gives 1, 2, 3, 0.
- R8: With `modeSel` = 1 (interleaved), the low two bits after n steps equal start XOR n. A start at 1 gives 1, 0, 3, 2.
- R9: After four steps the beat wraps, and `addrOut` returns to the captured start address.
- R10: Stepping never changes the address bits above the low two. A linear wrap from 3 to 0 does not carry into them.
- R11: A burst start takes priority over a low `advN` on the same edge. The address is reloaded from `addrIn`, not stepped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | Address sampled when a burst starts |
| procStrobeN | input | 1 | Processor-side burst start strobe, active low; gated by `chipEnN` |
| ctrlStrobeN | input | 1 | Controller-side burst start strobe, active low; deselects when `chipEnN` is high |
| advN | input | 1 | Advance to the next beat, active low |
| chipEnN | input | 1 | Primary chip enable, active low |
| modeSel | input | 1 | Beat order strap: 0 linear, 1 interleaved |
| addrOut | output | ADDR_W | Address of the current beat |

## Verification
Every result that comes from a clock edge is registered once, so it appears one edge after the stimulus that caused it. The bench changes inputs on the falling edge and waits for the next rising edge. It then compares `addrOut` a quarter period later, away from both edges. The reset result is asynchronous, so it is checked while reset is still held, with no clock edge needed. `modeSel` changes only on a cycle that reloads the burst, so every compared value belongs to a single order.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Per-cycle command from control to datapath
  typedef struct packed {
    logic load;  // capture addrIn, restart beat count
    logic step;  // advance beat count by one
  } burstCtl_t;

endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
(
  input  logic      procStrobeN,
  input  logic      ctrlStrobeN,
  input  logic      advN,
  input  logic      chipEnN,
  output burstCtl_t ctl
);

  logic procStart;
  logic ctrlStart;
  logic deselect;

  always_comb begin
    // processor strobe only counts when the chip is enabled
    procStart = !procStrobeN && !chipEnN;
    // controller strobe starts with chip enabled, deselects otherwise
    ctrlStart = !ctrlStrobeN && !chipEnN;
    deselect  = !ctrlStrobeN && chipEnN;
    ctl.load  = procStart || ctrlStart;
    ctl.step  = !ctl.load && !deselect && !advN;
  end

endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtl_t         ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              modeSel,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] lowLinear;
  logic [BEAT_W-1:0] lowInterleave;
  logic [BEAT_W-1:0] lowSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (ctl.load) begin
      baseAddr <= addrIn;
      beatCnt  <= '0;
    end else if (ctl.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  // both orders wrap inside BEAT_W bits; upper bits never see a carry
  always_comb begin
    lowLinear     = baseAddr[BEAT_W-1:0] + beatCnt;
    lowInterleave = baseAddr[BEAT_W-1:0] ^ beatCnt;
    lowSel        = modeSel ? lowInterleave : lowLinear;
  end

  generate
    if (UPPER_W > 0) begin : g_upper
      assign addrOut = {baseAddr[ADDR_W-1:BEAT_W], lowSel};
    end else begin : g_low_only
      assign addrOut = lowSel;
    end
  endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advN,
  input  logic              chipEnN,
  input  logic              modeSel,
  output logic [ADDR_W-1:0] addrOut
);

  burstCtl_t ctl;

  burst_addr_ctrl u_ctrl (
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advN        (advN),
    .chipEnN     (chipEnN),
    .ctl         (ctl)
  );

  burst_addr_dp #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .addrIn  (addrIn),
    .modeSel (modeSel),
    .addrOut (addrOut)
  );

endmodule

// File: rtl/burst_addr_gen_checker.sv
module burst_addr_gen_checker #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advN,
  input logic              chipEnN,
  input logic              modeSel,
  input logic [ADDR_W-1:0] addrOut
);

  logic startSeen;
  logic quietCycle;
  always_comb begin
    startSeen  = !chipEnN && (!procStrobeN || !ctrlStrobeN);
    quietCycle = !startSeen && ctrlStrobeN;
  end

  // R2: processor strobe with chip enabled captures the address
  assert_proc_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !chipEnN) |=> addrOut == $past(addrIn));

  // R3, R11: controller strobe with chip enabled captures, advance ignored
  assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && !chipEnN) |=> addrOut == $past(addrIn));

  // R4: gated processor strobe with advance high leaves address alone
  assert_proc_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (chipEnN && ctrlStrobeN && advN && $stable(modeSel)) |=> $stable(addrOut));

  // R5: deselect holds even with advance low
  assert_deselect_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chipEnN && !ctrlStrobeN) |=> (addrOut == $past(addrOut) || modeSel != $past(modeSel)));

  // R6: idle cycle with advance high holds
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (quietCycle && advN) |=> (addrOut == $past(addrOut) || modeSel != $past(modeSel)));

  // R7: linear step increments low bits modulo the burst length
  assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (quietCycle && !advN && !modeSel) |=>
      (modeSel || addrOut[BEAT_W-1:0] == $past(addrOut[BEAT_W-1:0]) + 1'b1));

  // R10: upper bits fixed unless a burst starts
  assert_upper_fixed_R10: assert property (@(posedge clk) disable iff (!rstN)
    !startSeen |=> addrOut[ADDR_W-1:BEAT_W] == $past(addrOut[ADDR_W-1:BEAT_W]));

endmodule

bind burst_addr_gen burst_addr_gen_checker #(
  .ADDR_W (ADDR_W),
  .BEAT_W (BEAT_W)
) u_chk (.*);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

  localparam int ADDR_W = 16;
  localparam int VEC_W  = 4 + 5 + 2 * ADDR_W;
  localparam int N_VEC  = 21;

  // fields: reqId[40:37] mode[36] ceN[35] procN[34] ctrlN[33] advN[32] addr[31:16] exp[15:0]
  localparam logic [VEC_W-1:0] VEC [N_VEC] = '{
    {4'd2,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'hA5C1, 16'hA5C1}, // R2 start linear at 1
    {4'd7,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'hA5C2}, // R7
    {4'd7,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'hA5C3}, // R7
    {4'd9,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'hA5C0}, // R9 wrap 3->0
    {4'd9,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'hA5C1}, // R9 back at start
    {4'd6,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 16'hA5C1}, // R6 hold
    {4'd11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1237, 16'h1237}, // R11 load beats advance
    {4'd10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h1234}, // R10 no carry
    {4'd4,  1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFF, 16'h1234}, // R4 ignored, hold
    {4'd4,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h1235}, // R4 ignored, steps
    {4'd5,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h1235}, // R5 deselect holds
    {4'd2,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0F01, 16'h0F01}, // R2 start interleaved
    {4'd8,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0F00}, // R8
    {4'd8,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0F03}, // R8
    {4'd8,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0F02}, // R8
    {4'd9,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0F01}, // R9
    {4'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'hBEE2, 16'hBEE2}, // R3 controller start
    {4'd8,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'hBEE3}, // R8
    {4'd8,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'hBEE0}, // R8
    {4'd6,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 16'hBEE0}, // R6 hold
    {4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0042, 16'h0042}  // R3 both strobes
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              procStrobeN = 1'b1;
  logic              ctrlStrobeN = 1'b1;
  logic              advN = 1'b1;
  logic              chipEnN = 1'b1;
  logic              modeSel = 1'b0;
  logic [ADDR_W-1:0] addrOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(2)) u_burst_addr_gen (
    .clk (clk), .rstN (rstN), .addrIn (addrIn),
    .procStrobeN (procStrobeN), .ctrlStrobeN (ctrlStrobeN),
    .advN (advN), .chipEnN (chipEnN), .modeSel (modeSel),
    .addrOut (addrOut)
  );

  task automatic check(input int reqId, input logic [ADDR_W-1:0] expVal);
    nChecks++;
    if (addrOut !== expVal) begin
      nFails++;
      $display("FAIL R%0d: addrOut actual %h expected %h", reqId, addrOut, expVal);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 5000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
    end
  end

  initial begin
    // R1: address cleared while reset held
    #13;
    check(1, '0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      modeSel     = VEC[i][36];
      chipEnN     = VEC[i][35];
      procStrobeN = VEC[i][34];
      ctrlStrobeN = VEC[i][33];
      advN        = VEC[i][32];
      addrIn      = VEC[i][31:16];
      @(posedge clk);
      #2;
      check(int'(VEC[i][40:37]), VEC[i][15:0]);
    end

    // R8: interleaved step from a start of 0x0042 gives low bits 2^1 = 3
    @(negedge clk);
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; chipEnN = 1'b1; advN = 1'b0;
    @(posedge clk); #2;
    check(8, 16'h0043);

    // R1: asynchronous reset mid-burst clears immediately
    @(negedge clk);
    advN = 1'b1;
    rstN = 1'b0;
    #1;
    check(1, '0);

    // R6: after reset release, advance from zero in linear order
    @(negedge clk);
    rstN = 1'b1; modeSel = 1'b0; advN = 1'b0;
    @(posedge clk); #2;
    check(6, 16'h0001);

    finished = 1'b1;
    finish_run();
  end

endmodule